// File: doc/BRIEF.md
# UART Terminating-Character Register Layer

This block is the register and flow-control layer that sits between a word-addressed slave bus and the character paths of a serial port. The receive path hands it whole characters with a one-cycle valid strobe. The block holds each one until the bus reads it. Characters that the bus writes to the transmit register go straight out to the transmit path as a one-cycle load strobe.

A programmable stop-character register is compared against every character that crosses the bus in either direction. On a match, the block does three things:

- It drives an end-of-packet sideband in the same cycle as the transfer, so a flow-controlled master such as a DMA engine ends its burst on that character.
- It sets a sticky status flag.
- If software has enabled it, it raises the interrupt.

A build-time parameter removes the whole stop-character feature. The register, the flag, the enable and the sideband then all read or drive zero.

Top module: `uart_pkt_term`

## Requirements
- R1: After reset the stop-character register (offset 5), the control register (offset 3) and the status register (offset 2) all read zero, and `irq` is low while `otherIrq` is low.
- R2: A write to word offset 5 stores the low `DATA_BITS` bits of the write data. A read of offset 5 returns them zero-extended, so bits at and above `DATA_BITS` read 0.
- R3: A `rxValid` pulse captures `rxChar` and sets status bit 7 (receive full) from the next cycle. A read of offset 0 returns the held character zero-extended and clears status bit 7 from the next cycle.
- R4: During a read of offset 0 while status bit 7 is set, `busEop` is high in that same cycle exactly when the held character equals the stop character.
- R5: A write to offset 1 pulses `txLoad` with `txChar` equal to the low `DATA_BITS` write bits. In that same cycle `busEop` is high exactly when those bits equal the stop character.
- R6: Status bit 12 (end-of-packet seen) reads 1 from the cycle after any `busEop` assertion. It stays 1 across later non-matching transfers.
- R7: Any write to offset 2 clears status bit 12 from the next cycle, unless a match occurs in that same cycle.
- R8: Control bit 12 is the end-of-packet interrupt enable. It is written and read back at offset 3.
- R9: `irq` equals (status bit 12 AND control bit 12) OR `otherIrq`.
- R10: With `EOP_EN` = 0, writes to offset 5 have no effect and it reads 0. Status bit 12 and control bit 12 read 0, and `busEop` never rises.
- R11: The comparison uses only the low `DATA_BITS` bits, so write-data bits above them do not affect a match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 3 | Word offset of the bus access |
| busRead | input | 1 | Read strobe, one cycle per access |
| busWrite | input | 1 | Write strobe, one cycle per access |
| busWdata | input | BUS_W | Write data |
| busRdata | output | BUS_W | Read data, valid in the read cycle |
| busEop | output | 1 | End-of-packet sideband qualifying the current transfer |
| rxValid | input | 1 | Receive path offers a new character |
| rxChar | input | DATA_BITS | Received character |
| txLoad | output | 1 | Transmit path takes `txChar` |
| txChar | output | DATA_BITS | Character for the transmit path |
| otherIrq | input | 1 | Other enabled interrupt sources, already combined |
| irq | output | 1 | Interrupt request |

## Verification
Read data, `busEop`, `txLoad` and `txChar` are combinational on the access and belong to the cycle of the strobe itself. The bench samples them one nanosecond after driving the strobe at the falling edge, before the next rising edge. Status bits, the control readback and `irq` change only on the rising edge that ends the access. The bench reads them in a later access, or samples them after the following falling edge. A full sweep of all 256 characters through the receive path, run for several stop characters, confirms that the sideband and the flag fire on the matching character alone. Every check is also made against a second instance built with the feature removed.

// File: rtl/term_pkg.sv
`timescale 1ns/1ps
package term_pkg;
  localparam int unsigned OFS_RXDATA = 0;
  localparam int unsigned OFS_TXDATA = 1;
  localparam int unsigned OFS_STATUS = 2;
  localparam int unsigned OFS_CTRL   = 3;
  localparam int unsigned OFS_TERM   = 5;
  localparam int unsigned BIT_RXFULL = 7;
  localparam int unsigned BIT_EOP    = 12;
  localparam int unsigned BIT_IEOP   = 12;

  typedef struct packed {
    logic rdRx;
    logic wrTx;
    logic wrStatus;
    logic wrCtrl;
    logic wrTerm;
  } strobe_t;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_RX,
    SEL_STATUS,
    SEL_CTRL,
    SEL_TERM
  } rdsel_t;
endpackage

// File: rtl/term_ctrl.sv
`timescale 1ns/1ps
module term_ctrl
  import term_pkg::*;
#(
  parameter bit EOP_EN = 1'b1,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busRead,
  input  logic              busWrite,
  input  logic              wdIeop,
  input  logic              rxMatch,
  input  logic              txMatch,
  input  logic              otherIrq,
  output strobe_t           strb,
  output rdsel_t            rdSel,
  output logic              eopFlag,
  output logic              ieop,
  output logic              busEop,
  output logic              irq
);
  // Address decode into one-cycle strobes for the datapath
  always_comb begin
    strb  = '0;
    rdSel = SEL_NONE;
    if (busRead) begin
      if (busAddr == ADDR_W'(OFS_RXDATA)) begin
        strb.rdRx = 1'b1;
        rdSel     = SEL_RX;
      end else if (busAddr == ADDR_W'(OFS_STATUS)) begin
        rdSel = SEL_STATUS;
      end else if (busAddr == ADDR_W'(OFS_CTRL)) begin
        rdSel = SEL_CTRL;
      end else if (busAddr == ADDR_W'(OFS_TERM)) begin
        rdSel = SEL_TERM;
      end
    end
    if (busWrite) begin
      strb.wrTx     = (busAddr == ADDR_W'(OFS_TXDATA));
      strb.wrStatus = (busAddr == ADDR_W'(OFS_STATUS));
      strb.wrCtrl   = (busAddr == ADDR_W'(OFS_CTRL));
      strb.wrTerm   = (busAddr == ADDR_W'(OFS_TERM));
    end
  end

  generate
    if (EOP_EN) begin : g_eop
      assign busEop = (strb.rdRx && rxMatch) || (strb.wrTx && txMatch);

      always_ff @(posedge clk) begin
        if (!rstN) begin
          eopFlag <= 1'b0;
          ieop    <= 1'b0;
        end else begin
          if (busEop)             eopFlag <= 1'b1;
          else if (strb.wrStatus) eopFlag <= 1'b0;
          if (strb.wrCtrl)        ieop    <= wdIeop;
        end
      end

      a_r6_set_after_match: assert property (@(posedge clk) disable iff (!rstN)
        busEop |=> eopFlag);
      a_r6_sticky: assert property (@(posedge clk) disable iff (!rstN)
        (eopFlag && !strb.wrStatus) |=> eopFlag);
      a_r7_clear_on_write: assert property (@(posedge clk) disable iff (!rstN)
        (strb.wrStatus && !busEop) |=> !eopFlag);
      a_r9_irq_follows: assert property (@(posedge clk) disable iff (!rstN)
        (busEop && ieop && !strb.wrCtrl) |=> irq);
    end else begin : g_noeop
      logic unusedMatch;
      assign unusedMatch = rxMatch ^ txMatch ^ wdIeop;
      assign busEop  = 1'b0;
      assign eopFlag = 1'b0;
      assign ieop    = 1'b0;
    end
  endgenerate

  assign irq = (eopFlag && ieop) || otherIrq;

  a_r3_strobe_excl: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.rdRx, strb.wrTx, strb.wrStatus, strb.wrCtrl, strb.wrTerm}) || (busRead && busWrite));
endmodule

// File: rtl/term_datapath.sv
`timescale 1ns/1ps
module term_datapath
  import term_pkg::*;
#(
  parameter int DATA_BITS = 8,
  parameter int BUS_W     = 16,
  parameter bit EOP_EN    = 1'b1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  strobe_t              strb,
  input  rdsel_t               rdSel,
  input  logic [DATA_BITS-1:0] wdChar,
  input  logic                 rxValid,
  input  logic [DATA_BITS-1:0] rxChar,
  input  logic                 eopFlag,
  input  logic                 ieop,
  output logic [BUS_W-1:0]     busRdata,
  output logic                 rxMatch,
  output logic                 txMatch,
  output logic                 txLoad,
  output logic [DATA_BITS-1:0] txChar
);
  logic [DATA_BITS-1:0] rxHold;
  logic                 rxFull;
  logic [DATA_BITS-1:0] termChar;
  logic                 unusedStrb;

  assign unusedStrb = strb.wrStatus ^ strb.wrCtrl ^ strb.wrTerm;

  // Receive holding register; a new character wins over a same-cycle read
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxHold <= '0;
      rxFull <= 1'b0;
    end else if (rxValid) begin
      rxHold <= rxChar;
      rxFull <= 1'b1;
    end else if (strb.rdRx) begin
      rxFull <= 1'b0;
    end
  end

  generate
    if (EOP_EN) begin : g_term
      always_ff @(posedge clk) begin
        if (!rstN)            termChar <= '0;
        else if (strb.wrTerm) termChar <= wdChar;
      end

      a_r2_term_store: assert property (@(posedge clk) disable iff (!rstN)
        strb.wrTerm |=> (termChar == $past(wdChar)));
    end else begin : g_noterm
      assign termChar = '0;
    end
  endgenerate

  assign rxMatch = rxFull && (rxHold == termChar);
  assign txMatch = (wdChar == termChar);
  assign txLoad  = strb.wrTx;
  assign txChar  = wdChar;

  always_comb begin
    busRdata = '0;
    unique case (rdSel)
      SEL_RX:     busRdata = BUS_W'(rxHold);
      SEL_STATUS: begin
        busRdata[BIT_RXFULL] = rxFull;
        busRdata[BIT_EOP]    = eopFlag;
      end
      SEL_CTRL:   busRdata[BIT_IEOP] = ieop;
      SEL_TERM:   busRdata = BUS_W'(termChar);
      default:    busRdata = '0;
    endcase
  end

  a_r3_capture: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |=> (rxFull && rxHold == $past(rxChar)));
  a_r3_drain: assert property (@(posedge clk) disable iff (!rstN)
    (strb.rdRx && !rxValid) |=> !rxFull);
endmodule

// File: rtl/uart_pkt_term.sv
`timescale 1ns/1ps
module uart_pkt_term
  import term_pkg::*;
#(
  parameter int DATA_BITS = 8,
  parameter int BUS_W     = 16,
  parameter bit EOP_EN    = 1'b1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [2:0]           busAddr,
  input  logic                 busRead,
  input  logic                 busWrite,
  input  logic [BUS_W-1:0]     busWdata,
  output logic [BUS_W-1:0]     busRdata,
  output logic                 busEop,
  input  logic                 rxValid,
  input  logic [DATA_BITS-1:0] rxChar,
  output logic                 txLoad,
  output logic [DATA_BITS-1:0] txChar,
  input  logic                 otherIrq,
  output logic                 irq
);
  localparam int ADDR_W = 3;

  strobe_t strb;
  rdsel_t  rdSel;
  logic    eopFlag;
  logic    ieop;
  logic    rxMatch;
  logic    txMatch;
  logic    unusedWdata;

  assign unusedWdata = ^busWdata;

  term_ctrl #(.EOP_EN(EOP_EN), .ADDR_W(ADDR_W)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .busAddr  (busAddr),
    .busRead  (busRead),
    .busWrite (busWrite),
    .wdIeop   (busWdata[BIT_IEOP]),
    .rxMatch  (rxMatch),
    .txMatch  (txMatch),
    .otherIrq (otherIrq),
    .strb     (strb),
    .rdSel    (rdSel),
    .eopFlag  (eopFlag),
    .ieop     (ieop),
    .busEop   (busEop),
    .irq      (irq)
  );

  term_datapath #(.DATA_BITS(DATA_BITS), .BUS_W(BUS_W), .EOP_EN(EOP_EN)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .rdSel    (rdSel),
    .wdChar   (busWdata[DATA_BITS-1:0]),
    .rxValid  (rxValid),
    .rxChar   (rxChar),
    .eopFlag  (eopFlag),
    .ieop     (ieop),
    .busRdata (busRdata),
    .rxMatch  (rxMatch),
    .txMatch  (txMatch),
    .txLoad   (txLoad),
    .txChar   (txChar)
  );
endmodule

// File: tb/tb_uart_pkt_term.sv
`timescale 1ns/1ps
module tb_uart_pkt_term;
  localparam int DB = 8;
  localparam int BW = 16;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [2:0]    busAddr = '0;
  logic          busRead = 1'b0;
  logic          busWrite = 1'b0;
  logic [BW-1:0] busWdata = '0;
  logic          rxValid = 1'b0;
  logic [DB-1:0] rxChar = '0;
  logic          otherIrq = 1'b0;

  logic [BW-1:0] rdOn, rdOff;
  logic          eopOn, eopOff, txLdOn, txLdOff, irqOn, irqOff;
  logic [DB-1:0] txOn, txOff;

  int nChecks = 0;
  int nFail = 0;
  bit done = 1'b0;

  logic [BW-1:0] capOn, capOff;
  logic          capEopOn, capEopOff, capTxLd;
  logic [DB-1:0] capTx;

  always #2.5 clk = ~clk;

  uart_pkt_term #(.DATA_BITS(DB), .BUS_W(BW), .EOP_EN(1'b1)) dut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busRead(busRead), .busWrite(busWrite),
    .busWdata(busWdata), .busRdata(rdOn), .busEop(eopOn), .rxValid(rxValid),
    .rxChar(rxChar), .txLoad(txLdOn), .txChar(txOn), .otherIrq(otherIrq), .irq(irqOn));

  uart_pkt_term #(.DATA_BITS(DB), .BUS_W(BW), .EOP_EN(1'b0)) dutOff (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busRead(busRead), .busWrite(busWrite),
    .busWdata(busWdata), .busRdata(rdOff), .busEop(eopOff), .rxValid(rxValid),
    .rxChar(rxChar), .txLoad(txLdOff), .txChar(txOff), .otherIrq(otherIrq), .irq(irqOff));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic busWr(input logic [2:0] a, input logic [BW-1:0] d);
    @(negedge clk);
    busAddr = a; busWdata = d; busWrite = 1'b1;
    #1;
    capEopOn = eopOn; capEopOff = eopOff; capTxLd = txLdOn; capTx = txOn;
    @(negedge clk);
    busWrite = 1'b0;
  endtask

  task automatic busRd(input logic [2:0] a);
    @(negedge clk);
    busAddr = a; busRead = 1'b1;
    #1;
    capOn = rdOn; capOff = rdOff; capEopOn = eopOn; capEopOff = eopOff;
    @(negedge clk);
    busRead = 1'b0;
  endtask

  task automatic pushRx(input logic [DB-1:0] c);
    @(negedge clk);
    rxValid = 1'b1; rxChar = c;
    @(negedge clk);
    rxValid = 1'b0;
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 150000);
    nChecks++; nFail++;
    $display("FAIL watchdog expired actual=hung expected=done");
    finishRun();
  end

  initial begin
    logic [DB-1:0] terms [4];
    terms[0] = 8'h00; terms[1] = 8'h55; terms[2] = 8'hA5; terms[3] = 8'hFF;

    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    busRd(3'd5); check("R1 term reset", capOn, 0);
    busRd(3'd3); check("R1 ctrl reset", capOn, 0);
    busRd(3'd2); check("R1 status reset", capOn, 0);
    check("R1 irq reset", irqOn, 0);

    // R2 stop register width; R10 disabled register
    busWr(3'd5, 16'hF1A5);
    busRd(3'd5);
    check("R2 term readback", capOn, 16'h00A5);
    check("R10 off term reads 0", capOff, 0);

    // R3/R4/R6/R7 sweep of all characters for several stop characters
    foreach (terms[t]) begin
      busWr(3'd5, {8'h00, terms[t]});
      busWr(3'd2, 16'h0000);
      for (int c = 0; c < 256; c++) begin
        pushRx(DB'(c));
        busRd(3'd2);
        check("R3 rx full set", 32'(capOn[7]), 1);
        busRd(3'd0);
        check("R3 rx data", capOn, 32'(c));
        check("R4 eop on read", 32'(capEopOn), 32'(DB'(c) == terms[t]));
        check("R10 off eop", 32'(capEopOff), 0);
        busRd(3'd2);
        check("R3 rx full cleared", 32'(capOn[7]), 0);
        check("R6 flag after match", 32'(capOn[12]), 32'(DB'(c) == terms[t]));
        check("R10 off flag", 32'(capOff[12]), 0);
        busWr(3'd2, 16'h0000);
      end
      busRd(3'd2);
      check("R7 flag cleared", 32'(capOn[12]), 0);
    end

    // R6 stickiness across a non-matching character
    busWr(3'd5, 16'h0042);
    pushRx(8'h42); busRd(3'd0);
    pushRx(8'h43); busRd(3'd0);
    check("R6 no eop on miss", 32'(capEopOn), 0);
    busRd(3'd2);
    check("R6 flag sticky", 32'(capOn[12]), 1);

    // R8 enable readback, R9 interrupt
    check("R9 irq masked", irqOn, 0);
    busWr(3'd3, 16'h1000);
    busRd(3'd3);
    check("R8 ctrl readback", capOn, 16'h1000);
    check("R10 off ctrl reads 0", capOff, 0);
    check("R9 irq on", irqOn, 1);
    check("R9 irq off instance", irqOff, 0);
    busWr(3'd2, 16'h0000);
    #1; check("R9 irq after clear", irqOn, 0);
    otherIrq = 1'b1;
    #1;
    check("R9 other source", irqOn, 1);
    check("R9 other source off", irqOff, 1);
    otherIrq = 1'b0;

    // R5/R11 transmit side
    busWr(3'd5, 16'h003C);
    busWr(3'd1, 16'hFF3C);
    check("R5 tx load", 32'(capTxLd), 1);
    check("R5 tx char", 32'(capTx), 32'h3C);
    check("R11 upper bits ignored", 32'(capEopOn), 1);
    check("R10 off tx eop", 32'(capEopOff), 0);
    busWr(3'd1, 16'h003D);
    check("R5 tx miss", 32'(capEopOn), 0);
    #1; check("R9 irq from tx match", irqOn, 1);
    busRd(3'd2);
    check("R6 flag from tx", 32'(capOn[12]), 1);
    check("R10 off status", capOff, 0);

    finishRun();
  end
endmodule